// File: doc/BRIEF.md
# Burst Bus Initiator Port

This block is the requesting side of a shared, synchronous burst bus. A local command names a direction (read or write), a starting byte address and a word count. The port asks the arbiter for the bus, opens the transaction with a single address cycle, and then moves words over as many data cycles as needed. A word crosses only on a clock edge where the port's own ready and the target's ready are both high. Either side can hold a data cycle back at any time.

The port closes a burst by lowering its frame line while it is still in the data phase, as soon as only one word remains. It also handles early endings. The target can ask to stop, which ends the transaction after that edge. The arbiter can take the grant back, after which the port finishes one more word and leaves the bus. In both cases the local side gets the number of words moved and the next address, so the rest can be issued again as a new command. If the grant is still parked on this port when a command arrives, the address cycle starts without a new request. After each transaction the shared lines stay undriven for at least one cycle.

Top module: `bib_initiator`

## Requirements
- R1: When no grant is present at command accept, `busReq` rises the next cycle and stays high until `busGnt` is sampled high. The address cycle follows in the cycle right after that edge.
- R2: The address cycle lasts one cycle. In it `frameOe`, `frameOut` and `adOe` are high, `irdyOe` is low, `adOut` carries the start address and `cbeOut` carries the command code (4'b0110 for read, 4'b0111 for write). If `busGnt` is already high when a command is accepted, the address cycle is the very next cycle and `busReq` never rises.
- R3: A word moves only on an edge where `irdyOut` and `trdyIn` are both high. On a write, `adOut` equals `wrData` and `wrPop` pulses in that cycle. On a read, `rdPush` pulses and `rdData` equals `adIn`. Word order is preserved.
- R4: `irdyOut` is low in any data cycle of a write where `wrAvail` is low, and in any data cycle of a read where `rdFull` is high.
- R5: In a data cycle, `frameOut` is high exactly while more than one word of the command remains. Once it is low it stays low until the transaction ends. The last word of a full burst moves with `frameOut` low.
- R6: When `stopIn` is sampled high in a data cycle, any word moving on that same edge counts, and the transaction then ends. `doneEarly` is 1, `doneCount` gives the words moved (0 if `trdyIn` was low), and `doneAddr` = start + 4 × `doneCount`.
- R7: If `busGnt` is sampled low in a data cycle, `frameOut` is low from the next cycle on. The port moves exactly one more word and then ends, reporting `doneEarly` = 1.
- R8: After frame and ready are released, all bus outputs stay undriven for at least one cycle before the next address cycle. `doneValid` pulses for one cycle in the first released cycle, together with `doneCount`, `doneEarly` and `doneAddr`. After reset, all bus outputs are undriven and `cmdReady` is high.
- R9: In the data cycles of a read, `adOe` is low so that the target can drive the address/data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every bus signal is sampled on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Local command offered |
| cmdReady | output | 1 | Port is idle and takes a command |
| cmdWrite | input | 1 | 1 = write burst, 0 = read burst |
| cmdAddr | input | W | Start byte address |
| cmdCount | input | CW | Words to move (at least 1) |
| wrData | input | W | Head word of the local write buffer |
| wrAvail | input | 1 | Write buffer holds at least one word |
| wrPop | output | 1 | Head write word consumed this cycle |
| rdData | output | W | Word read from the bus |
| rdPush | output | 1 | `rdData` is valid this cycle |
| rdFull | input | 1 | Local read buffer cannot take a word |
| doneValid | output | 1 | Transaction ended (one-cycle pulse) |
| doneCount | output | CW | Words moved by the ended transaction |
| doneEarly | output | 1 | Ended before all words were moved |
| doneAddr | output | W | Byte address of the first word not moved |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Grant from the arbiter |
| frameOut | output | 1 | Frame level (active high) |
| frameOe | output | 1 | Frame line driven |
| irdyOut | output | 1 | Initiator ready level |
| irdyOe | output | 1 | Initiator ready line driven |
| trdyIn | input | 1 | Target ready |
| stopIn | input | 1 | Target requests an end to the burst |
| adOut | output | W | Address/data value driven |
| adOe | output | 1 | Address/data lines driven |
| adIn | input | W | Address/data value from the target |
| cbeOut | output | 4 | Command in the address cycle, all-zero byte enables in data cycles |

## Verification
A corrupted remaining-word count shows up at once on `frameOut` in the data phase, because frame would drop a cycle too early or too late. It also shows up at the end of the burst in `doneCount` and `doneAddr`. A stuck or skipped transfer strobe appears in the same cycle: a popped or pushed word no longer lines up with the `irdyOut`/`trdyIn` handshake, or the word sequence on the bus breaks. A wrong sequencer state shows up within one cycle as a missing address cycle, a missing gap between transactions, or a request raised while the grant is parked. Stop and grant loss are checked through the words reported afterwards, so a port that keeps going past either one is caught by the count.

// File: rtl/bib_pkg.sv
`timescale 1ns/1ps
package bib_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_TURN
  } ctlState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;   // capture a new command
    logic step;   // one word crossed the bus
  } dpStrobe_t;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/bib_datapath.sv
`timescale 1ns/1ps
module bib_datapath
  import bib_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic          cmdWrite,
  input  logic [W-1:0]  cmdAddr,
  input  logic [CW-1:0] cmdCount,
  output logic [W-1:0]  curAddr,
  output logic          curWrite,
  output logic [CW-1:0] movedCount,
  output logic          remIsOne,
  output logic          remIsZero
);

  localparam int BYTES = W / 8;

  logic [W-1:0]  addrQ;
  logic [CW-1:0] remQ;
  logic [CW-1:0] movedQ;
  logic          writeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      remQ   <= '0;
      movedQ <= '0;
      writeQ <= 1'b0;
    end else if (strobe.load) begin
      addrQ  <= cmdAddr;
      remQ   <= cmdCount;
      movedQ <= '0;
      writeQ <= cmdWrite;
    end else if (strobe.step) begin
      addrQ  <= addrQ + W'(BYTES);
      remQ   <= remQ - CW'(1);
      movedQ <= movedQ + CW'(1);
    end
  end

  assign curAddr    = addrQ;
  assign curWrite   = writeQ;
  assign movedCount = movedQ;
  assign remIsOne   = (remQ == CW'(1));
  assign remIsZero  = (remQ == '0);

endmodule

// File: rtl/bib_control.sv
`timescale 1ns/1ps
module bib_control
  import bib_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      busGnt,
  input  logic      trdyIn,
  input  logic      stopIn,
  input  logic      wrAvail,
  input  logic      rdFull,
  input  logic      curWrite,
  input  logic      remIsOne,
  output dpStrobe_t strobe,
  output logic      cmdReady,
  output logic      busReq,
  output logic      isAddr,
  output logic      frameOut,
  output logic      frameOe,
  output logic      irdyOut,
  output logic      irdyOe,
  output logic      adOe,
  output logic      xfer,
  output logic      doneValid
);

  ctlState_t stateQ, stateD;
  logic      endPendQ;   // grant lost: next word is the last
  logic      accept;
  logic      inData;
  logic      canMove;

  assign inData   = (stateQ == ST_DATA);
  assign isAddr   = (stateQ == ST_ADDR);
  assign cmdReady = (stateQ == ST_IDLE);
  assign accept   = cmdValid && cmdReady;
  assign busReq   = (stateQ == ST_REQ);

  // local side throttles when it has nothing to give or no room to take
  assign canMove  = curWrite ? wrAvail : !rdFull;
  assign irdyOe   = inData;
  assign irdyOut  = inData && canMove;
  assign xfer     = irdyOut && trdyIn;

  assign frameOe  = isAddr || inData;
  assign frameOut = isAddr || (inData && !remIsOne && !endPendQ);
  assign adOe     = isAddr || (inData && curWrite);

  assign doneValid = (stateQ == ST_TURN);

  always_comb begin
    strobe.load = accept;
    strobe.step = xfer;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (accept) stateD = busGnt ? ST_ADDR : ST_REQ;
      ST_REQ:  if (busGnt) stateD = ST_ADDR;
      ST_ADDR: stateD = ST_DATA;
      ST_DATA: if (stopIn || (xfer && (remIsOne || endPendQ))) stateD = ST_TURN;
      ST_TURN: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      endPendQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (!inData)      endPendQ <= 1'b0;
      else if (!busGnt) endPendQ <= 1'b1;
    end
  end

endmodule

// File: rtl/bib_initiator.sv
`timescale 1ns/1ps
module bib_initiator
  import bib_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  output logic          cmdReady,
  input  logic          cmdWrite,
  input  logic [W-1:0]  cmdAddr,
  input  logic [CW-1:0] cmdCount,
  input  logic [W-1:0]  wrData,
  input  logic          wrAvail,
  output logic          wrPop,
  output logic [W-1:0]  rdData,
  output logic          rdPush,
  input  logic          rdFull,
  output logic          doneValid,
  output logic [CW-1:0] doneCount,
  output logic          doneEarly,
  output logic [W-1:0]  doneAddr,
  output logic          busReq,
  input  logic          busGnt,
  output logic          frameOut,
  output logic          frameOe,
  output logic          irdyOut,
  output logic          irdyOe,
  input  logic          trdyIn,
  input  logic          stopIn,
  output logic [W-1:0]  adOut,
  output logic          adOe,
  input  logic [W-1:0]  adIn,
  output logic [3:0]    cbeOut
);

  dpStrobe_t     strobe;
  logic [W-1:0]  curAddr;
  logic          curWrite;
  logic          remIsOne;
  logic          remIsZero;
  logic          isAddr;
  logic          xfer;

  bib_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .busGnt    (busGnt),
    .trdyIn    (trdyIn),
    .stopIn    (stopIn),
    .wrAvail   (wrAvail),
    .rdFull    (rdFull),
    .curWrite  (curWrite),
    .remIsOne  (remIsOne),
    .strobe    (strobe),
    .cmdReady  (cmdReady),
    .busReq    (busReq),
    .isAddr    (isAddr),
    .frameOut  (frameOut),
    .frameOe   (frameOe),
    .irdyOut   (irdyOut),
    .irdyOe    (irdyOe),
    .adOe      (adOe),
    .xfer      (xfer),
    .doneValid (doneValid)
  );

  bib_datapath #(.W(W), .CW(CW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdWrite   (cmdWrite),
    .cmdAddr    (cmdAddr),
    .cmdCount   (cmdCount),
    .curAddr    (curAddr),
    .curWrite   (curWrite),
    .movedCount (doneCount),
    .remIsOne   (remIsOne),
    .remIsZero  (remIsZero)
  );

  assign doneEarly = !remIsZero;
  assign doneAddr  = curAddr;

  assign adOut  = isAddr ? curAddr : wrData;
  assign cbeOut = isAddr ? (curWrite ? CMD_MEM_WR : CMD_MEM_RD) : 4'b0000;
  assign wrPop  = xfer && curWrite;
  assign rdPush = xfer && !curWrite;
  assign rdData = adIn;

endmodule

// File: rtl/bib_checker.sv
`timescale 1ns/1ps
module bib_checker (
  input logic clk,
  input logic rstN,
  input logic busReq,
  input logic busGnt,
  input logic frameOut,
  input logic frameOe,
  input logic irdyOut,
  input logic irdyOe,
  input logic trdyIn,
  input logic stopIn,
  input logic adOe,
  input logic wrPop,
  input logic wrAvail,
  input logic rdPush,
  input logic rdFull,
  input logic doneValid
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGnt |=> busReq); // R1

  AST_ADDR_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameOe) |-> frameOut && adOe && !irdyOe); // R2

  AST_MOVE_BOTH_READY: assert property (@(posedge clk) disable iff (!rstN)
    (wrPop || rdPush) |-> irdyOut && trdyIn); // R3

  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    wrPop |-> wrAvail); // R4

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    rdPush |-> !rdFull); // R4

  AST_FRAME_STAYS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    irdyOe && !frameOut |=> !frameOut); // R5

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    irdyOe && stopIn |=> !irdyOe && !frameOe); // R6

  AST_GNT_LOSS_LAST: assert property (@(posedge clk) disable iff (!rstN)
    irdyOe && !busGnt |=> !frameOut); // R7

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameOe) |=> !frameOe); // R8

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameOe) |-> doneValid); // R8

  AST_READ_RELEASES_AD: assert property (@(posedge clk) disable iff (!rstN)
    rdPush |-> !adOe); // R9

endmodule

bind bib_initiator bib_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busReq    (busReq),
  .busGnt    (busGnt),
  .frameOut  (frameOut),
  .frameOe   (frameOe),
  .irdyOut   (irdyOut),
  .irdyOe    (irdyOe),
  .trdyIn    (trdyIn),
  .stopIn    (stopIn),
  .adOe      (adOe),
  .wrPop     (wrPop),
  .wrAvail   (wrAvail),
  .rdPush    (rdPush),
  .rdFull    (rdFull),
  .doneValid (doneValid)
);

// File: tb/tb_bib_initiator.sv
`timescale 1ns/1ps
module tb_bib_initiator;

  localparam int W  = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [W-1:0]  cmdAddr = '0;
  logic [CW-1:0] cmdCount = '0;
  logic          cmdReady;
  logic [W-1:0]  wrData, rdData, adOut, adIn, doneAddr;
  logic          wrAvail, wrPop, rdPush, rdFull, doneValid, doneEarly;
  logic [CW-1:0] doneCount;
  logic          busReq, busGnt, frameOut, frameOe, irdyOut, irdyOe;
  logic          trdyIn, stopIn, adOe;
  logic [3:0]    cbeOut;

  // stand-in target, arbiter and local buffers
  logic gntV = 1'b0, stallOn = 1'b0, retryMode = 1'b0, wrThr = 1'b0, rdThr = 1'b0;
  logic chkFrame = 1'b1, curWr = 1'b0, pend = 1'b0;
  int   dropAt = 0, stopAt = 0, curCount = 0, cyc = 0, xferCnt = 0, xfBase = 0, rel;
  logic [W-1:0] wrIdx = '0;
  logic stopNow;

  assign rel     = xferCnt - xfBase;
  assign busGnt  = gntV && !(dropAt != 0 && rel >= dropAt);
  assign stopNow = irdyOe && stopAt != 0 && rel == stopAt - 1;
  assign stopIn  = stopNow;
  assign trdyIn  = irdyOe && !(stallOn && (cyc % 3 == 1)) && !(retryMode && stopNow);
  assign adIn    = 32'hB000_0000 + W'(xferCnt);
  assign wrData  = 32'hA000_0000 + wrIdx;
  assign wrAvail = !(wrThr && (cyc % 4 == 2));
  assign rdFull  = rdThr && (cyc % 4 == 1);

  bib_initiator #(.W(W), .CW(CW)) dut (.*);

  int nChk = 0, nFail = 0;
  int wrErr = 0, rdErr = 0, moveErr = 0, adErr = 0, frameErr = 0, irdyErr = 0, irdyLow = 0, turnErr = 0;
  int adrCyc = 0, accCyc = 0, gntCyc = 0, gapCnt = 100, minGap = 100;
  logic [W-1:0] adrAddr = '0, dAddr = '0;
  logic [3:0]   adrCbe = '0;
  logic         adrFrame = 1'b0, reqSeen = 1'b0, doneSeen = 1'b0, dEarly = 1'b0, lastOe = 1'b0, lastXferFrame = 1'b1;
  logic [CW-1:0] dCnt = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pend) begin
      xferCnt <= xferCnt + 1;
      if (curWr) wrIdx <= wrIdx + 1;
    end
  end

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    pend = irdyOe && irdyOut && trdyIn;
    if (pend) begin
      lastXferFrame = frameOut;
      if (curWr) begin
        if (!wrPop || !adOe || adOut !== wrData) wrErr++;
      end else begin
        if (!rdPush || rdData !== adIn) rdErr++;
      end
    end else if (wrPop || rdPush) moveErr++;
    if (irdyOe && !curWr && adOe) adErr++;
    if (irdyOe && chkFrame && frameOut !== ((curCount - rel) > 1)) frameErr++;
    if (irdyOe && irdyOut && (curWr ? !wrAvail : rdFull)) irdyErr++;
    if (irdyOe && !irdyOut) irdyLow++;
    if (frameOe && !irdyOe) begin
      adrAddr = adOut; adrCbe = cbeOut; adrFrame = frameOut; adrCyc = cyc;
    end
    if (busReq) reqSeen = 1'b1;
    if (doneValid) begin
      dCnt = doneCount; dEarly = doneEarly; dAddr = doneAddr; doneSeen = 1'b1;
      if (frameOe || irdyOe || adOe) turnErr++;
    end
    if (frameOe && !lastOe && gapCnt < minGap) minGap = gapCnt;
    if (frameOe) gapCnt = 0; else gapCnt++;
    lastOe = frameOe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runCmd(input logic wr, input logic [W-1:0] a, input int n, input int gntAfter);
    @(negedge clk); #1;
    curWr = wr; curCount = n; xfBase = xferCnt; doneSeen = 1'b0;
    cmdValid = 1'b1; cmdWrite = wr; cmdAddr = a; cmdCount = CW'(n);
    accCyc = cyc;
    while (!cmdReady) begin @(negedge clk); #1; accCyc = cyc; end
    @(negedge clk); #1;
    cmdValid = 1'b0;
    for (int k = 1; k < 400 && !doneSeen; k++) begin
      if (gntAfter != 0 && k == gntAfter) begin
        chk("R1 busReq held while waiting", {31'b0, busReq}, 1);
        chk("R1 no frame before grant", {31'b0, frameOe}, 0);
        gntV = 1'b1; gntCyc = cyc;
      end
      @(negedge clk); #1;
    end
    chk("R8 done reported", {31'b0, doneSeen}, 1);
  endtask

  task automatic clearErr();
    wrErr = 0; rdErr = 0; moveErr = 0; adErr = 0; frameErr = 0; irdyErr = 0; irdyLow = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 reset frameOe", {31'b0, frameOe}, 0);
    chk("R8 reset irdyOe", {31'b0, irdyOe}, 0);
    chk("R8 reset adOe", {31'b0, adOe}, 0);
    chk("R1 reset busReq", {31'b0, busReq}, 0);
    chk("R8 reset cmdReady", {31'b0, cmdReady}, 1);
  endtask

  task automatic t_grantWait();
    clearErr(); gntV = 1'b0;
    runCmd(1'b1, 32'h1000, 1, 3);
    chk("R1 address cycle after grant", adrCyc, gntCyc + 1);
    chk("R2 address value", adrAddr, 32'h1000);
    chk("R2 write command code", {28'b0, adrCbe}, 32'h7);
    chk("R2 frame in address cycle", {31'b0, adrFrame}, 1);
    chk("R3 single word count", {16'b0, dCnt}, 1);
    chk("R3 single word data", wrErr, 0);
    chk("R5 single word frame", frameErr, 0);
  endtask

  task automatic t_writeBurst();
    clearErr(); stallOn = 1'b1;
    runCmd(1'b1, 32'h2000, 6, 0);
    stallOn = 1'b0;
    chk("R3 write burst count", {16'b0, dCnt}, 6);
    chk("R3 write burst data", wrErr + moveErr, 0);
    chk("R5 write burst frame", frameErr, 0);
    chk("R5 last word frame low", {31'b0, lastXferFrame}, 0);
    chk("R6 full burst not early", {31'b0, dEarly}, 0);
    chk("R6 full burst next addr", dAddr, 32'h2018);
  endtask

  task automatic t_parking();
    clearErr(); reqSeen = 1'b0;
    runCmd(1'b0, 32'h3000, 1, 0);
    chk("R2 parked no request", {31'b0, reqSeen}, 0);
    chk("R2 parked address cycle next", adrCyc, accCyc + 1);
    chk("R2 read command code", {28'b0, adrCbe}, 32'h6);
  endtask

  task automatic t_readBurst();
    clearErr(); stallOn = 1'b1;
    runCmd(1'b0, 32'h4000, 5, 0);
    stallOn = 1'b0;
    chk("R3 read burst count", {16'b0, dCnt}, 5);
    chk("R3 read burst data", rdErr + moveErr, 0);
    chk("R9 read lines released", adErr, 0);
    chk("R5 read burst frame", frameErr, 0);
  endtask

  task automatic t_throttle();
    clearErr(); wrThr = 1'b1;
    runCmd(1'b1, 32'h4800, 7, 0);
    wrThr = 1'b0;
    chk("R4 write throttle count", {16'b0, dCnt}, 7);
    chk("R4 no ready on empty", irdyErr, 0);
    chk("R4 write throttle seen", {31'b0, irdyLow > 0}, 1);
    clearErr(); rdThr = 1'b1;
    runCmd(1'b0, 32'h4900, 7, 0);
    rdThr = 1'b0;
    chk("R4 read throttle count", {16'b0, dCnt}, 7);
    chk("R4 no ready on full", irdyErr, 0);
    chk("R4 read throttle seen", {31'b0, irdyLow > 0}, 1);
    chk("R3 throttled data", wrErr + rdErr + moveErr, 0);
  endtask

  task automatic t_stop();
    clearErr(); stopAt = 3;
    runCmd(1'b1, 32'h5000, 8, 0);
    stopAt = 0;
    chk("R6 stop count", {16'b0, dCnt}, 3);
    chk("R6 stop early", {31'b0, dEarly}, 1);
    chk("R6 stop next addr", dAddr, 32'h500C);
    runCmd(1'b1, dAddr, 5, 0);
    chk("R6 retry remainder count", {16'b0, dCnt}, 5);
    chk("R6 retry continues data", wrErr + moveErr, 0);
    stopAt = 1; retryMode = 1'b1;
    runCmd(1'b0, 32'h6000, 4, 0);
    stopAt = 0; retryMode = 1'b0;
    chk("R6 stop without data count", {16'b0, dCnt}, 0);
    chk("R6 stop without data early", {31'b0, dEarly}, 1);
    chk("R6 stop without data addr", dAddr, 32'h6000);
  endtask

  task automatic t_gntLoss();
    clearErr(); chkFrame = 1'b0; dropAt = 2;
    runCmd(1'b0, 32'h7000, 10, 0);
    dropAt = 0; chkFrame = 1'b1;
    chk("R7 grant loss count", {16'b0, dCnt}, 4);
    chk("R7 grant loss early", {31'b0, dEarly}, 1);
    chk("R7 grant loss addr", dAddr, 32'h7010);
    chk("R7 last word frame low", {31'b0, lastXferFrame}, 0);
    chk("R7 grant loss data", rdErr + moveErr, 0);
  endtask

  task automatic t_backToBack();
    clearErr(); minGap = 100; turnErr = 0;
    runCmd(1'b1, 32'h8000, 2, 0);
    runCmd(1'b0, 32'h9000, 2, 0);
    chk("R8 idle gap between transactions", {31'b0, minGap >= 1}, 1);
    chk("R8 done with lines released", turnErr, 0);
    chk("R3 back to back data", wrErr + rdErr + moveErr, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run hung (actual=running expected=finished)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_grantWait();
    t_writeBurst();
    t_parking();
    t_readBurst();
    t_throttle();
    t_stop();
    t_gntLoss();
    t_backToBack();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule